// File: doc/BRIEF.md
# Delay-Window Best Phase Selector

This block receives a pass/fail map from a delay-line calibration sweep. Bit i of the map is set when delay tap i gave a good transfer. The block finds the longest run of consecutive passing taps. It reports where that run begins, how long it is, and a recommended sampling tap inside it. Software or a calibration sequencer builds the map, then pulses `start`. The result appears with a one-cycle `done` pulse, and the chosen tap is then programmed into the delay line.

The scanner walks the map one tap per clock, from tap 0 upward. It keeps the first of any equally long runs. It stops early when it has already found a long window close to tap 0. The recommended tap is skewed towards the low end when the winning window begins at tap 0, because the true left edge of such a window is unknown. When no tap passed, the phase output carries a fixed failure code.

Top module: `phase_window_picker`

## Requirements
- R1: When the map captured at start is all zeros, the result reports phase 8'hFF, best_len 0 and best_start 0.
- R2: A run that begins at tap s counts consecutive set bits from s upward. It ends at the first clear bit or after tap TAPS-1 (31). It never wraps from tap 31 back to tap 0.
- R3: The reported window is the longest run in the map. When several runs have the same length, the one with the lowest start tap is reported.
- R4: The scan stops as soon as a finished run of length 8 or more leaves the recorded best start below 4. Any later run, however long, is then not considered.
- R5: When best_start is 0, phase is best_len/3. Otherwise phase is (best_start + best_len/2) mod 32. Both use integer division, and the result sits in the low bits of the 8-bit phase port.
- R6: A high `start` while idle captures `map_in` and sets `busy`. A `start` while busy is ignored, and a change of `map_in` after capture has no effect on the result.
- R7: `done` is high for exactly one cycle per scan, and it rises at most 33 clock cycles after the cycle in which `start` was accepted.
- R8: best_start, best_len and phase change only in the cycle where `done` is raised. They hold their value until the next scan completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan of `map_in` (accepted only when idle) |
| map_in | input | 32 | Pass/fail map, bit i for delay tap i |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| best_start | output | 5 | First tap of the chosen window |
| best_len | output | 6 | Length of the chosen window (0 to 32) |
| phase | output | 8 | Recommended sampling tap, or 8'hFF when no tap passed |

## Verification
The bench drives every single-window map (every start and every length) and every single-tap map. It also drives a long series of pseudo-random maps and compares each result with an arithmetic model of the window rule. Targeted maps cover the following cases:
- Equal-length ties. A design that replaced the best run on equal length would report the later run.
- A window that touches tap 31 next to one at tap 0. A wrap-around design would merge them into one run.
- A long window near tap 0 followed by a longer window. A design without the early exit would pick the later one.
- The early exit sitting exactly at length 8 and start 4. A design with an off-by-one threshold would fail here.

The bench also pulses `start` and changes `map_in` in the middle of a scan. A design that re-captured the map would return the second map's answer.

// File: rtl/phase_window_picker.sv
module phase_window_picker #(
  parameter int TAPS       = 32,
  parameter int EXIT_LEN   = 8,
  parameter int EXIT_START = 4,
  parameter int PW         = 8,
  parameter logic [PW-1:0] FAIL_CODE = 8'hFF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [TAPS-1:0]             map_in,
  output logic                        busy,
  output logic                        done,
  output logic [$clog2(TAPS)-1:0]     best_start,
  output logic [$clog2(TAPS+1)-1:0]   best_len,
  output logic [PW-1:0]               phase
);
  localparam int IW = $clog2(TAPS);
  localparam int LW = $clog2(TAPS+1);

  logic [TAPS-1:0] map_q;
  logic [IW-1:0]   idx, run_start, acc_start;
  logic [LW-1:0]   cur_len, acc_len;

  wire           bit_now  = map_q[idx];
  wire           at_top   = (idx == IW'(TAPS-1));
  wire [IW-1:0]  rs       = (cur_len == '0) ? idx : run_start;
  wire [LW-1:0]  fin_len  = bit_now ? cur_len + LW'(1) : cur_len;
  wire           run_end  = bit_now ? at_top : (cur_len != '0);
  wire           better   = run_end && (fin_len > acc_len);
  wire [IW-1:0]  nb_start = better ? rs : acc_start;
  wire [LW-1:0]  nb_len   = better ? fin_len : acc_len;
  wire           early    = run_end && (fin_len >= LW'(EXIT_LEN)) &&
                            (nb_start < IW'(EXIT_START));
  wire           stop     = busy && (at_top || early);

  logic [PW-1:0] nxt_phase;
  logic [LW:0]   mid_sum;
  always_comb begin
    mid_sum = (LW+1)'(nb_start) + (LW+1)'(nb_len / LW'(2));
    if (nb_len == '0)
      nxt_phase = FAIL_CODE;
    else if (nb_start == '0)
      nxt_phase = PW'(nb_len / LW'(3));
    else
      nxt_phase = PW'(mid_sum % (LW+1)'(TAPS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q      <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      idx        <= '0;
      run_start  <= '0;
      cur_len    <= '0;
      acc_start  <= '0;
      acc_len    <= '0;
      best_start <= '0;
      best_len   <= '0;
      phase      <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          map_q     <= map_in;
          busy      <= 1'b1;
          idx       <= '0;
          cur_len   <= '0;
          run_start <= '0;
          acc_start <= '0;
          acc_len   <= '0;
        end
      end else begin
        acc_start <= nb_start;
        acc_len   <= nb_len;
        run_start <= rs;
        cur_len   <= bit_now ? cur_len + LW'(1) : '0;
        idx       <= idx + IW'(1);
        if (stop) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          best_start <= nb_start;
          best_len   <= nb_len;
          phase      <= nxt_phase;
        end
      end
    end
  end

  logic [LW:0] scan_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    scan_cnt <= '0;
    else if (busy) scan_cnt <= scan_cnt + (LW+1)'(1);
    else           scan_cnt <= '0;
  end

  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> scan_cnt < (LW+1)'(TAPS)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_EMPTY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && best_len == '0) |-> (phase == FAIL_CODE && best_start == '0)); // R1
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && best_len != '0) |-> phase < PW'(TAPS)); // R5
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (LW+1)'(best_start) + (LW+1)'(best_len) <= (LW+1)'(TAPS)); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(phase) && $stable(best_len) && $stable(best_start))); // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop) |=> busy); // R6
endmodule

// File: tb/tb_phase_window_picker.sv
module tb_phase_window_picker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] map_in = '0;
  logic        busy, done;
  logic [4:0]  best_start;
  logic [5:0]  best_len;
  logic [7:0]  phase;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  phase_window_picker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .map_in(map_in),
    .busy(busy), .done(done), .best_start(best_start),
    .best_len(best_len), .phase(phase)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] m, output int s,
                                output int l, output int ph);
    int p, n;
    s = 0; l = 0; p = 0;
    if (m == 0) begin ph = 255; return; end
    while (p < 32) begin
      n = 0;
      while (p + n < 32 && m[p+n]) n++;
      if (n > l) begin s = p; l = n; end
      p += (n != 0) ? n : 1;
      if (n >= 8 && s < 4) break;
    end
    ph = (s == 0) ? l / 3 : (s + l / 2) % 32;
  endfunction

  task automatic run_map(input logic [31:0] m, input string req);
    int es, el, ep, lat;
    model(m, es, el, ep);
    @(negedge clk);
    map_in = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check({req, " R7 latency"}, int'(lat <= 33), 1);
    check({req, " start"}, best_start, es);
    check({req, " len"}, best_len, el);
    check({req, " phase"}, phase, ep);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    int ss, sl, sp;
    repeat (3) @(negedge clk);
    check("R8 reset done", done, 0);
    check("R6 reset busy", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_map(32'h0, "R1 empty");
    check("R1 code", phase, 8'hFF);
    run_map(32'hFFFF_FFFF, "R5 all pass");
    check("R5 all pass phase", phase, 10);
    run_map(32'h8000_0001, "R2 no wrap");
    check("R2 no wrap len", best_len, 1);
    run_map(32'h0000_0F0F, "R3 tie first");
    check("R3 tie start", best_start, 0);
    run_map(32'hFFFF_F1FF, "R4 early exit");
    check("R4 early len", best_len, 9);
    run_map(32'hFFFF_E0FF, "R4 exit at 8");
    check("R4 exit at 8 len", best_len, 8);
    run_map(32'hFFFF_0FF0, "R4 start 4 no exit");
    check("R4 start 4 len", best_len, 16);
    run_map(32'h00FF_F000, "R5 mid");
    check("R5 mid phase", phase, 18);

    for (int b = 0; b < 32; b++) run_map(32'h1 << b, "R2 single");
    for (int s = 0; s < 32; s++)
      for (int l = 1; l <= 32 - s; l++)
        run_map(((l == 32) ? 32'hFFFF_FFFF : ((32'h1 << l) - 1)) << s, "R3 window");
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_map(lfsr | (lfsr >> 3), "R3 random");
    end

    model(32'h0000_7FF0, ss, sl, sp);
    @(negedge clk);
    map_in = 32'h0000_7FF0;
    start = 1'b1;
    @(negedge clk);
    map_in = 32'hFFFF_FFFF;
    repeat (5) @(negedge clk);
    map_in = 32'h0;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R6 ignore start len", best_len, sl);
    check("R6 ignore start phase", phase, sp);
    map_in = 32'hFFFF_FFFF;
    repeat (10) @(negedge clk);
    check("R8 hold len", best_len, sl);
    check("R8 hold phase", phase, sp);
    check("R7 done pulse", done, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule